// File: doc/BRIEF.md
# Dual-Divider Rational Frequency Synthesis Controller

This controller sets an oscillator's target frequency as the ratio of two small integers instead of one large feedback division from a slow reference. It counts reference edges and oscillator edges, each by its own divisor. Both edges arrive as single-cycle strobes in the system clock domain. Each count produces a one-cycle pulse, and a downstream phase detector compares the two pulse trains. The comparison rate therefore stays near the reference rate divided by a small number, rather than dropping to a kilohertz.

A 4-bit frequency code selects one of sixteen built-in ratio entries. Each entry holds a feedback divisor, a reference divisor and a flag that picks an alternate reference source. The alternate source covers frequencies that no small ratio of the 10 MHz primary reaches. For example, code 0 gives 19/20, which is 9.5 MHz, and code 5 gives 148/153, about 9.673 MHz.

A new code is adopted only in a cycle where both dividers hit terminal count together, or at synchronous reset. This keeps the two pulse trains phase-coherent across a retune. An entry holding a divisor of 0 or 1 is refused and flagged.

Top module: `rfs_synth`

## Requirements
- R1: While `rst` is high at a clock edge, both pulse outputs are low after that edge and both divider counts restart from zero. The entry selected by `freq_code` becomes active if it is valid.
- R2: `ref_pulse` is high for exactly the one cycle after the clock edge at which `ref_tick` completes a group of `ref_div` reference strobes. It is low in every other cycle.
- R3: `fb_pulse` behaves the same way for `osc_tick`, using the feedback divisor.
- R4: The table gives (feedback, reference, alternate-flag) for each code. Codes 0 to 11 use the primary source: 0:(19,20), 1:(39,40), 2:(79,80), 3:(99,100), 4:(199,200), 5:(148,153), 6:(29,30), 7:(59,60), 8:(2,2), 9:(49,50), 10:(119,120), 11:(97,100). Codes 12 and 13 use the alternate source: 12:(200,209), 13:(150,151). Code 14 is (0,20) and code 15 is (19,1).
- R5: A change of `freq_code` has no effect on divisors or `ref_alt_sel` until an edge at which both dividers reach terminal count. The new divisors govern counting from the next strobe onward.
- R6: An entry with either divisor equal to 0 or 1 is never loaded. At such a load point the previous setting is kept and `cfg_err` goes high. At reset, an invalid entry loads code 0's setting instead and also raises `cfg_err`.
- R7: `cfg_err` goes low at the next load point that sees a valid entry.
- R8: `ref_alt_sel` equals the alternate flag of the active entry.
- R9: A cycle with no strobe on a divider leaves that divider's count unchanged and produces no pulse from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_code | input | 4 | Ratio table selector |
| ref_tick | input | 1 | One-cycle strobe per reference edge |
| osc_tick | input | 1 | One-cycle strobe per oscillator edge |
| ref_pulse | output | 1 | Divided reference pulse |
| fb_pulse | output | 1 | Divided feedback pulse |
| ref_alt_sel | output | 1 | High selects the alternate reference |
| cfg_err | output | 1 | Last load attempt met an invalid entry |

## Verification
Each input pattern checks a different part of the behaviour:
- Both strobes every cycle runs each divider at its full rate and reaches the first coincidence after a known number of cycles. This separates a correct reload from an early or late one.
- A sparse pattern stalls the reference strobe and sometimes both strobes. It shows whether a count advances without a strobe and whether the two dividers are truly independent.
- Code changes made well before a coincidence show whether a retune waits for the joint terminal count.
- The two invalid codes, and a later valid code, exercise refusal of bad entries, recovery from the error, and the alternate-source flag.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int RFS_DIV_W  = 8;
  localparam int RFS_CODE_W = 4;

  typedef struct packed {
    logic [RFS_DIV_W-1:0] fb;
    logic [RFS_DIV_W-1:0] rf;
    logic                 alt;
  } ratio_t;

  function automatic ratio_t mk_ratio(input int unsigned f, input int unsigned r, input logic a);
    ratio_t t;
    t.fb  = RFS_DIV_W'(f);
    t.rf  = RFS_DIV_W'(r);
    t.alt = a;
    return t;
  endfunction

  // Built-in ratio table, one entry per frequency code.
  function automatic ratio_t ratio_lookup(input logic [RFS_CODE_W-1:0] code);
    case (code)
      4'd0:    return mk_ratio(19, 20, 1'b0);
      4'd1:    return mk_ratio(39, 40, 1'b0);
      4'd2:    return mk_ratio(79, 80, 1'b0);
      4'd3:    return mk_ratio(99, 100, 1'b0);
      4'd4:    return mk_ratio(199, 200, 1'b0);
      4'd5:    return mk_ratio(148, 153, 1'b0);
      4'd6:    return mk_ratio(29, 30, 1'b0);
      4'd7:    return mk_ratio(59, 60, 1'b0);
      4'd8:    return mk_ratio(2, 2, 1'b0);
      4'd9:    return mk_ratio(49, 50, 1'b0);
      4'd10:   return mk_ratio(119, 120, 1'b0);
      4'd11:   return mk_ratio(97, 100, 1'b0);
      4'd12:   return mk_ratio(200, 209, 1'b1);
      4'd13:   return mk_ratio(150, 151, 1'b1);
      4'd14:   return mk_ratio(0, 20, 1'b0);
      default: return mk_ratio(19, 1, 1'b0);
    endcase
  endfunction

  // A divisor below two cannot produce a periodic pulse.
  function automatic logic ratio_ok(input ratio_t t);
    return (t.fb >= RFS_DIV_W'(2)) && (t.rf >= RFS_DIV_W'(2));
  endfunction

  localparam ratio_t RATIO_FALLBACK = '{fb: 8'd19, rf: 8'd20, alt: 1'b0};
endpackage

// File: rtl/rfs_divider.sv
module rfs_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] div,
  output logic         term,
  output logic         pulse
);
  logic [W-1:0] cnt;

  // Terminal event: the strobe that completes a group of div strobes.
  assign term = tick && (cnt == div - W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= term;
      if (term)      cnt <= '0;
      else if (tick) cnt <= cnt + W'(1);
    end
  end

  // R2 / R3: count always below the active divisor
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst) cnt < div);
  // R3: pulses are isolated single cycles
  a_r3_pulse_single: assert property (@(posedge clk) disable iff (rst) pulse |=> !pulse);
  // R9: no strobe, no movement, no pulse
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(cnt) && !pulse));
endmodule

// File: rtl/rfs_ratio_ctrl.sv
module rfs_ratio_ctrl
  import rfs_pkg::*;
#(
  parameter int CODE_W = RFS_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              fb_term,
  input  logic              ref_term,
  output ratio_t            active,
  output logic              cfg_err,
  output logic              swap_evt
);
  ratio_t cand;
  logic   cand_ok;

  assign cand     = ratio_lookup(RFS_CODE_W'(code));
  assign cand_ok  = ratio_ok(cand);
  assign swap_evt = fb_term && ref_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= cand_ok ? cand : RATIO_FALLBACK;
      cfg_err <= !cand_ok;
    end else if (swap_evt) begin
      if (cand_ok) active <= cand;
      cfg_err <= !cand_ok;
    end
  end

  // R5: setting moves only at a joint terminal count
  a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
    !swap_evt |=> $stable(active));
  // R6: an invalid entry is refused and flagged
  a_r6_refuse_bad: assert property (@(posedge clk) disable iff (rst)
    (swap_evt && !cand_ok) |=> ($stable(active) && cfg_err));
  // R6: the active setting never carries a divisor below two
  a_r6_active_valid: assert property (@(posedge clk) disable iff (rst)
    (active.fb >= 8'd2) && (active.rf >= 8'd2));
  // R7: a valid load clears the flag
  a_r7_err_clears: assert property (@(posedge clk) disable iff (rst)
    (swap_evt && cand_ok) |=> !cfg_err);
endmodule

// File: rtl/rfs_synth.sv
module rfs_synth
  import rfs_pkg::*;
#(
  parameter int DIV_W  = RFS_DIV_W,
  parameter int CODE_W = RFS_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] freq_code,
  input  logic              ref_tick,
  input  logic              osc_tick,
  output logic              ref_pulse,
  output logic              fb_pulse,
  output logic              ref_alt_sel,
  output logic              cfg_err
);
  ratio_t active;
  logic   fb_term, ref_term, swap_evt;

  rfs_ratio_ctrl #(.CODE_W(CODE_W)) i_ctrl (
    .clk(clk), .rst(rst), .code(freq_code),
    .fb_term(fb_term), .ref_term(ref_term),
    .active(active), .cfg_err(cfg_err), .swap_evt(swap_evt)
  );

  rfs_divider #(.W(DIV_W)) i_fb_div (
    .clk(clk), .rst(rst), .tick(osc_tick), .div(DIV_W'(active.fb)),
    .term(fb_term), .pulse(fb_pulse)
  );

  rfs_divider #(.W(DIV_W)) i_ref_div (
    .clk(clk), .rst(rst), .tick(ref_tick), .div(DIV_W'(active.rf)),
    .term(ref_term), .pulse(ref_pulse)
  );

  assign ref_alt_sel = active.alt;

  // R8: the source flag follows the setting and moves only at a load point
  a_r8_sel_stable: assert property (@(posedge clk) disable iff (rst)
    !swap_evt |=> $stable(ref_alt_sel));
  // R2 / R5: a load point always emits both pulses on the next cycle
  a_r5_joint_pulses: assert property (@(posedge clk) disable iff (rst)
    swap_evt |=> (fb_pulse && ref_pulse));
endmodule

// File: tb/test_rfs_synth.sv
module test_rfs_synth;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] freq_code = 4'd0;
  logic       ref_tick = 1'b0, osc_tick = 1'b0;
  logic       ref_pulse, fb_pulse, ref_alt_sel, cfg_err;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // Expected state, kept from the requirements
  int e_fb, e_rf, oc, rc;
  bit e_alt, e_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfs_synth i_rfs_synth (
    .clk(clk), .rst(rst), .freq_code(freq_code),
    .ref_tick(ref_tick), .osc_tick(osc_tick),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .ref_alt_sel(ref_alt_sel), .cfg_err(cfg_err)
  );

  // Table restated from R4 as (feedback, reference, alternate)
  task automatic entry(input int c, output int f, output int r, output bit a);
    int fbs[16] = '{19,39,79,99,199,148,29,59,2,49,119,97,200,150,0,19};
    int rfs[16] = '{20,40,80,100,200,153,30,60,2,50,120,100,209,151,20,1};
    f = fbs[c]; r = rfs[c]; a = (c == 12 || c == 13);
  endtask

  task automatic check(input string tag, input bit ok, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic do_reset(input int c, input string tag);
    int f, r; bit a;
    freq_code = 4'(c); rst = 1'b1; ref_tick = 0; osc_tick = 0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    entry(c, f, r, a);
    oc = 0; rc = 0;
    if (f >= 2 && r >= 2) begin e_fb = f; e_rf = r; e_alt = a; e_err = 0; end
    else begin e_fb = 19; e_rf = 20; e_alt = 0; e_err = 1; end
    check(tag, ref_pulse == 0 && fb_pulse == 0 && ref_alt_sel == e_alt && cfg_err == e_err,
      $sformatf("after reset pulses=%0b%0b sel=%0b err=%0b expected 00 %0b %0b",
                ref_pulse, fb_pulse, ref_alt_sel, cfg_err, e_alt, e_err));
  endtask

  task automatic step(input bit o, input bit r, input string tag);
    bit ft, rt; int f, rr; bit a;
    osc_tick = o; ref_tick = r;
    @(posedge clk); @(negedge clk);
    ft = o && (oc == e_fb - 1);
    rt = r && (rc == e_rf - 1);
    oc = ft ? 0 : oc + int'(o);
    rc = rt ? 0 : rc + int'(r);
    if (ft && rt) begin
      entry(int'(freq_code), f, rr, a);
      if (f >= 2 && rr >= 2) begin e_fb = f; e_rf = rr; e_alt = a; e_err = 0; end
      else e_err = 1;
    end
    check(tag, fb_pulse == ft && ref_pulse == rt && ref_alt_sel == e_alt && cfg_err == e_err,
      $sformatf("fb=%0b ref=%0b sel=%0b err=%0b expected %0b %0b %0b %0b",
                fb_pulse, ref_pulse, ref_alt_sel, cfg_err, ft, rt, e_alt, e_err));
  endtask

  task automatic t_reset;
    do_reset(0, "R1");
    check("R1", ref_alt_sel == 0 && cfg_err == 0,
          $sformatf("sel=%0b err=%0b expected 0 0", ref_alt_sel, cfg_err));
  endtask

  task automatic t_full_rate;
    int nr = 0, nf = 0;
    for (int k = 1; k <= 400; k++) begin
      step(1, 1, "R2");
      nr += int'(ref_pulse); nf += int'(fb_pulse);
    end
    check("R2", nr == 20, $sformatf("ref pulses %0d expected 20", nr));
    check("R3", nf == 21, $sformatf("fb pulses %0d expected 21", nf));
  endtask

  task automatic t_sparse;
    for (int k = 1; k <= 300; k++) begin
      if (k % 5 == 0) step(0, 0, "R9");
      else step(1, (k % 3 == 0), "R9");
    end
  endtask

  task automatic t_ratio_148;
    int first_fb = 0, first_rf = 0;
    do_reset(5, "R4");
    for (int k = 1; k <= 320; k++) begin
      step(1, 1, "R4");
      if (fb_pulse && first_fb == 0) first_fb = k;
      if (ref_pulse && first_rf == 0) first_rf = k;
    end
    check("R4", first_fb == 148 && first_rf == 153,
          $sformatf("first pulses fb=%0d ref=%0d expected 148 153", first_fb, first_rf));
  endtask

  task automatic t_retune;
    do_reset(0, "R5");
    for (int k = 1; k <= 100; k++) step(1, 1, "R5");
    freq_code = 4'd12;
    for (int k = 101; k <= 379; k++) step(1, 1, "R5");
    check("R5", ref_alt_sel == 0, $sformatf("sel=%0b before joint count, expected 0", ref_alt_sel));
    step(1, 1, "R5");
    check("R8", ref_alt_sel == 1, $sformatf("sel=%0b after joint count, expected 1", ref_alt_sel));
    for (int k = 1; k <= 420; k++) step(1, 1, "R5");
  endtask

  task automatic t_invalid;
    do_reset(15, "R6");
    check("R6", cfg_err == 1, $sformatf("err=%0b after bad reset, expected 1", cfg_err));
    freq_code = 4'd0;
    for (int k = 1; k <= 380; k++) step(1, 1, "R7");
    check("R7", cfg_err == 0, $sformatf("err=%0b after good load, expected 0", cfg_err));
    freq_code = 4'd14;
    for (int k = 1; k <= 380; k++) step(1, 1, "R6");
    check("R6", cfg_err == 1, $sformatf("err=%0b after refused load, expected 1", cfg_err));
    for (int k = 1; k <= 40; k++) step(1, 1, "R6");
    freq_code = 4'd13;
    for (int k = 1; k <= 380; k++) step(1, 1, "R7");
    check("R7", cfg_err == 0 && ref_alt_sel == 1,
          $sformatf("err=%0b sel=%0b expected 0 1", cfg_err, ref_alt_sel));
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_full_rate();
    t_sparse();
    t_ratio_148();
    t_retune();
    t_invalid();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule